// File: doc/BRIEF.md
# Nibble-Serial Arithmetic, Logic and Compare Unit

This unit performs 16-bit integer arithmetic, bitwise logic and comparisons over a 4-bit datapath. A caller raises `start` together with the operation code and the lowest nibble of both operands. It then presents the next three nibbles on the following three cycles, lowest first. Each result nibble appears combinationally in the cycle its operand nibbles are on the inputs. The carry chain and the partial comparison state are held in registers between nibbles. `done` marks the fourth and final nibble.

Compare operations produce no data result. They write a single predicate bit at the clock edge that ends their `done` cycle. A modifier can be loaded while the unit is idle. It makes the next N operations combine the compare result into the predicate by AND or by OR, or pass the final carry or borrow of one add or subtract into the next, so that wider words can be chained. When the count runs out, the unit falls back to plain overwrite with no carry carried over.

Top module: `nsalu_top`

## Requirements
- R1: A `start` accepted while idle launches an operation whose nibble k (k = 0..3, least significant first) is taken from `b_nib`/`c_nib` in the k-th cycle counted from the start cycle. `done` is high only in the cycle of nibble 3.
- R2: Op codes 0 ADD (B+C), 1 SUB (B-C), 6 INC (B+1) and 7 DEC (B-1) return a 16-bit result modulo 2^16, with carry and borrow passed between nibbles. The C operand of INC and DEC is ignored.
- R3: Op codes 2 AND (B&C), 3 ANDN (B&~C), 4 OR (B|C), 5 XOR (B^C) and 8 NOT (~B) return the bitwise result on `res_nib`.
- R4: Compare codes 9 EQ (B==C), 10 NE (B!=C) and 15 ANY (B&C nonzero) produce a one-bit result.
- R5: Compare codes 11 LT (signed B<C), 12 LTU (unsigned B<C), 13 GE (signed B>=C) and 14 GEU (unsigned B>=C) produce a one-bit result.
- R6: `res_valid` is high during all four nibble cycles of an op with code 0..8 and low during a compare. `pred` changes only at the edge that ends the `done` cycle of a compare. Arithmetic and logic ops leave it untouched.
- R7: `mod_kind` 2 (AND-accumulate) makes a compare write pred & result.
- R8: `mod_kind` 3 (OR-accumulate) makes a compare write pred | result.
- R9: `mod_kind` 1 (chained carry) makes an ADD take the carry-out of the previous ADD as its carry-in. It also makes a SUB take in the borrow left by the previous SUB. The first op after loading sees no carry and no borrow.
- R10: A modifier applies to the next `mod_count` completed operations of any kind, after which plain overwrite returns with the chained carry cleared. A count of 0 applies no modifier.
- R11: `start` is ignored while an operation is in flight, including its `done` cycle. `mod_load` is ignored unless the unit is idle and `start` is low.
- R12: After reset the unit is idle, `pred` is 0 and no modifier is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation; nibble 0 on the inputs this cycle |
| op | input | 4 | Operation code, sampled with an accepted start |
| b_nib | input | 4 | Current nibble of operand B |
| c_nib | input | 4 | Current nibble of operand C |
| mod_load | input | 1 | Load a modifier (idle only) |
| mod_kind | input | 2 | 0 none, 1 chained carry, 2 AND-accumulate, 3 OR-accumulate |
| mod_count | input | 4 | Number of following operations the modifier covers |
| res_nib | output | 4 | Result nibble of the current cycle |
| res_valid | output | 1 | res_nib carries a data result |
| done | output | 1 | Final nibble of the operation |
| pred | output | 1 | Predicate bit |

## Verification
The bench targets carries that ripple through every nibble boundary, such as 0x0FFF+1 and 0-1. A unit that dropped the registered carry would return a wrong upper nibble for these. Signed and unsigned orderings are split by operands near 0x8000 and 0x7FFF. A unit that judged the sign from the wrong nibble, or ignored overflow, would invert the signed answers. The modifier checks count operations through expiry and confirm that the carry dies with the mode. They also load modifiers and raise start in the middle of an operation. A unit that honoured those would corrupt the result or the predicate.

// File: rtl/nsalu_pkg.sv
package nsalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_ANDN = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_NOT  = 4'd8,
        OP_EQ   = 4'd9,
        OP_NE   = 4'd10,
        OP_LT   = 4'd11,
        OP_LTU  = 4'd12,
        OP_GE   = 4'd13,
        OP_GEU  = 4'd14,
        OP_ANY  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        MOD_NONE  = 2'd0,
        MOD_CARRY = 2'd1,
        MOD_PAND  = 2'd2,
        MOD_POR   = 2'd3
    } mod_e;

    // State carried from one nibble to the next
    typedef struct packed {
        logic carry;
        logic eq;
        logic any;
    } run_flags_t;

    function automatic logic is_cmp(alu_op_e o);
        return o >= OP_EQ;
    endfunction

    function automatic logic inverts_c(alu_op_e o);
        return (o == OP_SUB) || is_cmp(o);
    endfunction

    // Carry into nibble 0; chain selects the stored carry/borrow
    function automatic logic start_cin(alu_op_e o, logic chain, logic stk);
        case (o)
            OP_ADD:  return chain ? stk : 1'b0;
            OP_SUB:  return chain ? ~stk : 1'b1;
            OP_INC:  return 1'b1;
            default: return inverts_c(o);
        endcase
    endfunction

endpackage

// File: rtl/nsalu_slice.sv
module nsalu_slice
    import nsalu_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  alu_op_e          op,
    input  logic [NIB_W-1:0] b,
    input  logic [NIB_W-1:0] c,
    input  run_flags_t       run_in,
    output logic [NIB_W-1:0] res,
    output run_flags_t       run_out,
    output logic             cmp_res
);
    localparam int MSB = NIB_W - 1;

    logic [NIB_W-1:0] c_eff;
    logic [NIB_W-1:0] sum;
    logic             cout;
    logic             ovf;
    logic             lt_s;

    always_comb begin
        case (op)
            OP_INC:  c_eff = '0;
            OP_DEC:  c_eff = '1;
            default: c_eff = inverts_c(op) ? ~c : c;
        endcase
    end

    assign {cout, sum} = {1'b0, b} + {1'b0, c_eff} + {{NIB_W{1'b0}}, run_in.carry};

    // Signed overflow of B - C is decided from the top bits
    assign ovf  = (b[MSB] != c[MSB]) && (sum[MSB] != b[MSB]);
    assign lt_s = sum[MSB] ^ ovf;

    always_comb begin
        run_out.carry = cout;
        run_out.eq    = run_in.eq & (b == c);
        run_out.any   = run_in.any | (|(b & c));
    end

    always_comb begin
        case (op)
            OP_AND:  res = b & c;
            OP_ANDN: res = b & ~c;
            OP_OR:   res = b | c;
            OP_XOR:  res = b ^ c;
            OP_NOT:  res = ~b;
            default: res = sum;
        endcase
    end

    always_comb begin
        case (op)
            OP_EQ:   cmp_res = run_out.eq;
            OP_NE:   cmp_res = ~run_out.eq;
            OP_LT:   cmp_res = lt_s;
            OP_LTU:  cmp_res = ~cout;
            OP_GE:   cmp_res = ~lt_s;
            OP_GEU:  cmp_res = cout;
            OP_ANY:  cmp_res = run_out.any;
            default: cmp_res = 1'b0;
        endcase
    end

endmodule

// File: rtl/nsalu_seq.sv
module nsalu_seq
    import nsalu_pkg::*;
#(
    parameter int NIBS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  alu_op_e    op_in,
    input  logic       cin0,
    input  run_flags_t run_out,
    output logic       accept,
    output logic       active,
    output logic       busy,
    output logic       last,
    output alu_op_e    op_eff,
    output run_flags_t run_in
);
    localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    alu_op_e          op_q;
    run_flags_t       run_q;
    run_flags_t       run_init;

    assign accept = start && !busy_q;
    assign active = accept || busy_q;
    assign busy   = busy_q;
    assign last   = busy_q && (idx_q == LAST_IDX);
    assign op_eff = busy_q ? op_q : op_in;

    always_comb begin
        run_init.carry = cin0;
        run_init.eq    = 1'b1;
        run_init.any   = 1'b0;
    end

    assign run_in = busy_q ? run_q : run_init;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            op_q   <= OP_ADD;
            run_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= IDX_W'(1);
            op_q   <= op_in;
            run_q  <= run_out;
        end else if (busy_q) begin
            run_q <= run_out;
            if (last) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/nsalu_pred.sv
module nsalu_pred
    import nsalu_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             mod_load,
    input  mod_e             mod_kind,
    input  logic [CNT_W-1:0] mod_count,
    input  logic             done,
    input  alu_op_e          done_op,
    input  logic             cmp_res,
    input  logic             fin_cout,
    output logic             pred,
    output mod_e             mode_eff,
    output logic             stk
);
    logic             pred_q;
    mod_e             mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stk_q;
    logic             load_ok;
    logic             pred_nx;

    assign load_ok  = mod_load && idle;
    assign mode_eff = (cnt_q != '0) ? mode_q : MOD_NONE;
    assign pred     = pred_q;
    assign stk      = stk_q;

    always_comb begin
        case (mode_eff)
            MOD_PAND: pred_nx = pred_q & cmp_res;
            MOD_POR:  pred_nx = pred_q | cmp_res;
            default:  pred_nx = cmp_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= 1'b0;
            mode_q <= MOD_NONE;
            cnt_q  <= '0;
            stk_q  <= 1'b0;
        end else if (load_ok) begin
            mode_q <= mod_kind;
            cnt_q  <= (mod_kind == MOD_NONE) ? '0 : mod_count;
            stk_q  <= 1'b0;
        end else if (done) begin
            if (is_cmp(done_op)) begin
                pred_q <= pred_nx;
            end
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    mode_q <= MOD_NONE;
                    stk_q  <= 1'b0;
                end else if (mode_q == MOD_CARRY) begin
                    if (done_op == OP_ADD) begin
                        stk_q <= fin_cout;
                    end else if (done_op == OP_SUB) begin
                        stk_q <= ~fin_cout;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/nsalu_top.sv
module nsalu_top
    import nsalu_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int NIBS  = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [3:0]       op,
    input  logic [NIB_W-1:0] b_nib,
    input  logic [NIB_W-1:0] c_nib,
    input  logic             mod_load,
    input  logic [1:0]       mod_kind,
    input  logic [CNT_W-1:0] mod_count,
    output logic [NIB_W-1:0] res_nib,
    output logic             res_valid,
    output logic             done,
    output logic             pred
);
    logic       accept_w;
    logic       active_w;
    logic       busy_w;
    logic       last_w;
    alu_op_e    op_eff;
    run_flags_t run_in;
    run_flags_t run_out;
    logic       cmp_res;
    logic       cin0;
    mod_e       mode_eff;
    logic       stk_carry;

    assign cin0 = start_cin(alu_op_e'(op), mode_eff == MOD_CARRY, stk_carry);

    nsalu_seq #(
        .NIBS (NIBS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_in   (alu_op_e'(op)),
        .cin0    (cin0),
        .run_out (run_out),
        .accept  (accept_w),
        .active  (active_w),
        .busy    (busy_w),
        .last    (last_w),
        .op_eff  (op_eff),
        .run_in  (run_in)
    );

    nsalu_slice #(
        .NIB_W (NIB_W)
    ) u_slice (
        .op      (op_eff),
        .b       (b_nib),
        .c       (c_nib),
        .run_in  (run_in),
        .res     (res_nib),
        .run_out (run_out),
        .cmp_res (cmp_res)
    );

    nsalu_pred #(
        .CNT_W (CNT_W)
    ) u_pred (
        .clk       (clk),
        .rst       (rst),
        .idle      (!active_w && !start),
        .mod_load  (mod_load),
        .mod_kind  (mod_e'(mod_kind)),
        .mod_count (mod_count),
        .done      (last_w),
        .done_op   (op_eff),
        .cmp_res   (cmp_res),
        .fin_cout  (run_out.carry),
        .pred      (pred),
        .mode_eff  (mode_eff),
        .stk       (stk_carry)
    );

    assign done      = last_w;
    assign res_valid = active_w && !is_cmp(op_eff);

endmodule

// File: rtl/nsalu_chk.sv
module nsalu_chk
    import nsalu_pkg::*;
#(
    parameter int NIBS = 4
) (
    input logic clk,
    input logic rst,
    input logic accept,
    input logic busy,
    input logic done,
    input logic pred,
    input mod_e mode_eff,
    input logic stk
);
    logic [7:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
        end else if (accept) begin
            since_q <= 8'd1;
        end else if (busy) begin
            since_q <= since_q + 8'd1;
        end
    end

    // R1
    done_on_last_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (since_q == 8'(NIBS - 1)));

    // R1
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    pred_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(pred));

    // R10
    carry_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_eff != MOD_CARRY) |-> !stk);

    // R11
    busy_keeps_going_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

bind nsalu_top nsalu_chk #(
    .NIBS (NIBS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept_w),
    .busy     (busy_w),
    .done     (done),
    .pred     (pred),
    .mode_eff (mode_eff),
    .stk      (stk_carry)
);

// File: tb/test_nsalu_top.sv
module test_nsalu_top;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] op = 4'd0;
    logic [3:0] b_nib = 4'd0;
    logic [3:0] c_nib = 4'd0;
    logic       mod_load = 1'b0;
    logic [1:0] mod_kind = 2'd0;
    logic [3:0] mod_count = 4'd0;
    logic [3:0] res_nib;
    logic       res_valid;
    logic       done;
    logic       pred;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    nsalu_top i_nsalu_top (
        .clk(clk), .rst(rst), .start(start), .op(op), .b_nib(b_nib), .c_nib(c_nib),
        .mod_load(mod_load), .mod_kind(mod_kind), .mod_count(mod_count),
        .res_nib(res_nib), .res_valid(res_valid), .done(done), .pred(pred)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_res(input int o, input logic [15:0] b, input logic [15:0] c);
        case (o)
            0: return b + c;
            1: return b - c;
            2: return b & c;
            3: return b & ~c;
            4: return b | c;
            5: return b ^ c;
            6: return b + 16'd1;
            7: return b - 16'd1;
            8: return ~b;
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic model_cmp(input int o, input logic [15:0] b, input logic [15:0] c);
        case (o)
            9:  return b == c;
            10: return b != c;
            11: return $signed(b) < $signed(c);
            12: return b < c;
            13: return $signed(b) >= $signed(c);
            14: return b >= c;
            15: return (b & c) != 16'd0;
            default: return 1'b0;
        endcase
    endfunction

    // Runs one operation, checks the per-nibble framing (R1, R6), returns the result.
    task automatic run_op(input int o, input logic [15:0] b, input logic [15:0] c,
                          output logic [15:0] res);
        logic p_before;
        p_before = pred;
        res = 16'd0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            start = (k == 0);
            op    = 4'(o);
            b_nib = b[4*k +: 4];
            c_nib = c[4*k +: 4];
            #(PERIOD/4);
            res[4*k +: 4] = res_nib;
            check(done == (k == 3), "R1 done framing", int'(done), int'(k == 3));
            check(res_valid == (o < 9), "R6 res_valid", int'(res_valid), int'(o < 9));
            check(pred == p_before, "R6 pred steady mid-op", int'(pred), int'(p_before));
        end
        @(negedge clk);
        start = 1'b0;
        b_nib = 4'd0;
        c_nib = 4'd0;
        #1;
    endtask

    task automatic do_data(input string req, input int o, input logic [15:0] b, input logic [15:0] c);
        logic [15:0] r;
        run_op(o, b, c, r);
        check(r == model_res(o, b, c), req, int'(r), int'(model_res(o, b, c)));
    endtask

    task automatic do_cmp(input string req, input int o, input logic [15:0] b, input logic [15:0] c,
                          input logic exp_p);
        logic [15:0] r;
        run_op(o, b, c, r);
        check(pred == exp_p, req, int'(pred), int'(exp_p));
    endtask

    task automatic set_mod(input int kind, input int cnt);
        @(negedge clk);
        mod_load  = 1'b1;
        mod_kind  = 2'(kind);
        mod_count = 4'(cnt);
        @(negedge clk);
        mod_load = 1'b0;
    endtask

    task automatic t_reset();
        check(pred == 1'b0, "R12 pred after reset", int'(pred), 0);
        check(res_valid == 1'b0, "R12 idle after reset", int'(res_valid), 0);
        check(done == 1'b0, "R12 no done after reset", int'(done), 0);
    endtask

    task automatic t_arith();
        do_data("R2 add ripple", 0, 16'h0FFF, 16'h0001);
        do_data("R2 add wrap", 0, 16'hFFFF, 16'h0001);
        do_data("R2 add mixed", 0, 16'h1234, 16'h5678);
        do_data("R2 sub borrow", 1, 16'h0000, 16'h0001);
        do_data("R2 sub mixed", 1, 16'h8000, 16'h0F01);
        do_data("R2 inc ignores C", 6, 16'h00FF, 16'hABCD);
        do_data("R2 dec ignores C", 7, 16'h1000, 16'h5555);
    endtask

    task automatic t_logic();
        do_data("R3 and", 2, 16'hF0F0, 16'h3C3C);
        do_data("R3 andn", 3, 16'hF0F0, 16'h3C3C);
        do_data("R3 or", 4, 16'h1200, 16'h0034);
        do_data("R3 xor", 5, 16'hFFFF, 16'hA5A5);
        do_data("R3 not", 8, 16'h0F3C, 16'h1111);
    endtask

    task automatic t_eq_any();
        do_cmp("R4 eq true", 9, 16'hBEEF, 16'hBEEF, model_cmp(9, 16'hBEEF, 16'hBEEF));
        do_cmp("R4 eq top nibble differs", 9, 16'hBEEF, 16'hAEEF, 1'b0);
        do_cmp("R4 ne low nibble differs", 10, 16'h1230, 16'h1231, 1'b1);
        do_cmp("R4 any hit", 15, 16'h0100, 16'h0300, 1'b1);
        do_cmp("R4 any miss", 15, 16'hF0F0, 16'h0F0F, 1'b0);
    endtask

    task automatic t_order();
        do_cmp("R5 lt signed neg", 11, 16'h8000, 16'h7FFF, model_cmp(11, 16'h8000, 16'h7FFF));
        do_cmp("R5 ltu same bits", 12, 16'h8000, 16'h7FFF, model_cmp(12, 16'h8000, 16'h7FFF));
        do_cmp("R5 ge signed", 13, 16'h7FFF, 16'hFFFF, model_cmp(13, 16'h7FFF, 16'hFFFF));
        do_cmp("R5 geu equal", 14, 16'h4321, 16'h4321, 1'b1);
        do_cmp("R5 lt equal", 11, 16'h4321, 16'h4321, 1'b0);
        do_cmp("R5 ltu small", 12, 16'h0001, 16'h0002, 1'b1);
    endtask

    task automatic t_pred_hold();
        do_cmp("R6 set pred", 9, 16'h0005, 16'h0005, 1'b1);
        do_data("R6 add keeps pred", 0, 16'h0001, 16'h0001);
        check(pred == 1'b1, "R6 pred after add", int'(pred), 1);
    endtask

    task automatic t_and_acc();
        do_cmp("R7 prime", 9, 16'h0, 16'h0, 1'b1);
        set_mod(2, 3);
        do_cmp("R7 and true", 11, 16'h0001, 16'h0002, 1'b1);
        do_cmp("R7 and false", 14, 16'h0001, 16'h0002, 1'b0);
        do_cmp("R7 and stays low", 9, 16'h0003, 16'h0003, 1'b0);
    endtask

    task automatic t_or_acc();
        do_cmp("R8 prime", 9, 16'h0, 16'h1, 1'b0);
        set_mod(3, 2);
        do_cmp("R8 or false", 10, 16'h0004, 16'h0004, 1'b0);
        do_cmp("R8 or true", 15, 16'h0100, 16'h0300, 1'b1);
        do_cmp("R8 plain after count", 9, 16'h0001, 16'h0002, 1'b0);
    endtask

    task automatic t_sticky();
        logic [15:0] r;
        set_mod(1, 2);
        run_op(0, 16'hFFFF, 16'h0001, r);
        check(r == 16'h0000, "R9 low add", int'(r), 16'h0000);
        run_op(0, 16'h0001, 16'h0000, r);
        check(r == 16'h0002, "R9 high add takes carry", int'(r), 16'h0002);
        run_op(0, 16'h0000, 16'h0000, r);
        check(r == 16'h0000, "R10 carry gone after count", int'(r), 16'h0000);
        set_mod(1, 2);
        run_op(1, 16'h0000, 16'h0001, r);
        check(r == 16'hFFFF, "R9 low sub", int'(r), 16'hFFFF);
        run_op(1, 16'h0001, 16'h0000, r);
        check(r == 16'h0000, "R9 high sub takes borrow", int'(r), 16'h0000);
        run_op(1, 16'h0005, 16'h0003, r);
        check(r == 16'h0002, "R10 plain sub after count", int'(r), 16'h0002);
    endtask

    task automatic t_count();
        do_cmp("R10 prime", 9, 16'h7, 16'h7, 1'b1);
        set_mod(2, 2);
        do_data("R10 add consumes count", 0, 16'h1, 16'h1);
        do_cmp("R10 and in force", 9, 16'h1, 16'h2, 1'b0);
        do_cmp("R10 overwrite after expiry", 9, 16'h2, 16'h2, 1'b1);
        set_mod(3, 0);
        do_cmp("R10 count zero no modifier", 9, 16'h1, 16'h2, 1'b0);
    endtask

    task automatic t_ignore();
        logic [15:0] r;
        logic [15:0] b;
        logic [15:0] c;
        b = 16'h1357;
        c = 16'h2468;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            start = (k != 2);
            op    = (k == 0) ? 4'd0 : 4'd5;
            b_nib = b[4*k +: 4];
            c_nib = c[4*k +: 4];
            #(PERIOD/4);
            r[4*k +: 4] = res_nib;
        end
        @(negedge clk);
        start = 1'b0;
        #(PERIOD/4);
        check(r == 16'h37BF, "R11 start mid-op ignored", int'(r), 16'h37BF);
        check(res_valid == 1'b0, "R11 no op from start in done cycle", int'(res_valid), 0);
        do_cmp("R11 prime", 9, 16'h9, 16'h9, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            start    = (k == 0);
            op       = 4'd0;
            mod_load = (k == 2);
            mod_kind = 2'd3;
            mod_count = 4'd3;
        end
        @(negedge clk);
        start    = 1'b0;
        mod_load = 1'b0;
        do_cmp("R11 mod_load mid-op ignored", 9, 16'h1, 16'h2, 1'b0);
        @(negedge clk);
        start    = 1'b1;
        mod_load = 1'b1;
        mod_kind = 2'd3;
        mod_count = 4'd3;
        op       = 4'd0;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            start    = 1'b0;
            mod_load = 1'b0;
        end
        @(negedge clk);
        do_cmp("R11 prime again", 9, 16'h4, 16'h4, 1'b1);
        do_cmp("R11 mod_load with start ignored", 9, 16'h1, 16'h2, 1'b0);
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_arith();
        t_logic();
        t_eq_any();
        t_order();
        t_pred_hold();
        t_and_acc();
        t_or_acc();
        t_sticky();
        t_count();
        t_ignore();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule